// File: doc/BRIEF.md
# Double-Buffered DRAM Timing Register Bank

This block holds the timing parameters that steer a DRAM command sequencer. Every parameter exists twice. Software writes the shadow copy over a simple register bus. The sequencer sees only the active copy, which is driven out on a wide port. Software can stage a complete new timing set for a coming clock-rate change while the old set stays in force.

The whole shadow set moves into the active set in one clock edge. This happens on either of two events. The first is a clock-change handshake with the clock controller, which is allowed only when software has enabled it and has chosen a DRAM suspend mode. The second is a software write to a force bit. A completed handshake raises a status flag. A refresh-overflow pulse raises a second flag. Both flags are write-one-to-clear. A masked OR of the flags drives an interrupt line.

Top module: `dtb_timing_shadow_bank`

## Requirements
- R1: A write to the shadow window (byte offset 0x100 + 4*i, i below NUM_TIMING) updates shadow entry i, which reads back from that offset on the next cycle; the active set, on the port and in the active window (0x200 + 4*i), keeps its value.
- R2: Writing control (0x008) with bit 0 = 1 copies every shadow entry into the active set at that clock edge, and the copy is visible on the next cycle; writing control with bit 0 = 0 changes nothing.
- R3: While config bit 0 (enable) is 1 and at least one of config bits 1 (power-down) and 2 (self-refresh) is 1, a high clk_chg_req seen at an edge in the idle state commits shadow to active at that edge. clk_chg_ack is high from the next cycle until the edge after the request falls. Exactly one commit is made per request, and shadow writes made while ack is high stay uncommitted.
- R4: A request seen while enable is 0, or while both mode bits are 0, commits nothing, raises no acknowledge and sets no status bit.
- R5: The status register (0x000) sets bit 4 on the edge of a handshake commit and bit 3 on any cycle with refresh_ovf high. A forced update sets no status bit.
- R6: Writing status clears each set bit whose write-data bit is 1 and leaves the others; a set event in the same cycle as a clear keeps the bit set.
- R7: The mask register (0x004) stores bits 3 and 4, with other bits reading 0; irq is high whenever some status bit and the same mask bit are both 1.
- R8: Reads of the active window return the active set; writes to it are ignored. Control, unmapped offsets and unaligned accesses read 0. bus_rdata is 0 unless a read is in progress.
- R9: After reset all shadow and active entries, status, mask and config are 0, and ack and irq are low.
- R10: The config register (0x00C) stores bits 2..0 and reads them back, with upper bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| clk_chg_req | input | 1 | Clock-change request from the clock controller |
| clk_chg_ack | output | 1 | Clock-change acknowledge |
| refresh_ovf | input | 1 | Refresh-overflow event pulse |
| timing_active | output | NUM_TIMING*DATA_W | Active timing set, entry i at bits [i*DATA_W +: DATA_W] |
| irq | output | 1 | Masked interrupt |

## Verification
A shadow entry that holds a wrong value stays hidden until the next commit. It then shows on timing_active one cycle after the commit edge, and it shows at once on a shadow-window read. A stuck or wrong handshake state shows on clk_chg_ack in the cycle after the request edge. A missed or double commit shows as active values that differ from a shadow set staged before or during the acknowledge. Status and mask faults show on irq and on status reads in the cycle after the event. The reference model is compared against every output on every clock, so any such fault is caught within one cycle of becoming observable.

// File: rtl/dtb_pkg.sv
package dtb_pkg;
    localparam int ADDR_W = 12;
    localparam int WIN_W  = 6;

    localparam logic [ADDR_W-1:0] A_STATUS = 12'h000;
    localparam logic [ADDR_W-1:0] A_MASK   = 12'h004;
    localparam logic [ADDR_W-1:0] A_CTRL   = 12'h008;
    localparam logic [ADDR_W-1:0] A_CFG    = 12'h00C;
    localparam logic [3:0]        PG_SHADOW = 4'h1;
    localparam logic [3:0]        PG_ACTIVE = 4'h2;

    localparam int BIT_FORCE = 0;
    localparam int BIT_OVF   = 3;
    localparam int BIT_DONE  = 4;
    localparam int CFG_EN    = 0;
    localparam int CFG_PD    = 1;
    localparam int CFG_SR    = 2;

    typedef enum logic {
        HS_IDLE = 1'b0,
        HS_HELD = 1'b1
    } hs_state_e;
endpackage

// File: rtl/dtb_regif.sv
module dtb_regif
    import dtb_pkg::*;
#(
    parameter int NUM_TIMING = 44,
    parameter int DATA_W     = 32,
    localparam int IW        = (NUM_TIMING > 1) ? $clog2(NUM_TIMING) : 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               bus_en,
    input  logic                               bus_we,
    input  logic [ADDR_W-1:0]                  bus_addr,
    input  logic [2:0]                         low_wdata,
    input  logic [NUM_TIMING-1:0][DATA_W-1:0]  shadow,
    input  logic [NUM_TIMING-1:0][DATA_W-1:0]  active,
    input  logic [DATA_W-1:0]                  status_word,
    input  logic [DATA_W-1:0]                  mask_word,
    output logic [DATA_W-1:0]                  bus_rdata,
    output logic                               sh_we,
    output logic [IW-1:0]                      sh_idx,
    output logic                               force_upd,
    output logic                               st_clr_we,
    output logic                               mask_we,
    output logic                               cfg_en,
    output logic [1:0]                         cfg_mode
);
    localparam logic [WIN_W:0] NUM_L = (WIN_W + 1)'(NUM_TIMING);

    typedef struct packed {
        logic [2:0] cfg;
    } regs_t;

    regs_t             r_d, r_q;
    logic              wr, rd, aligned, in_win;
    logic [3:0]        page;
    logic [WIN_W-1:0]  win;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] ref_a);
        return a[ADDR_W-1:2] == ref_a[ADDR_W-1:2];
    endfunction

    always_comb begin
        aligned   = (bus_addr[1:0] == 2'b00);
        wr        = bus_en && bus_we && aligned;
        rd        = bus_en && !bus_we && aligned;
        page      = bus_addr[ADDR_W-1:8];
        win       = bus_addr[7:2];
        in_win    = {1'b0, win} < NUM_L;
        sh_idx    = win[IW-1:0];
        sh_we     = wr && (page == PG_SHADOW) && in_win;
        force_upd = wr && hit(bus_addr, A_CTRL) && low_wdata[BIT_FORCE];
        st_clr_we = wr && hit(bus_addr, A_STATUS);
        mask_we   = wr && hit(bus_addr, A_MASK);

        r_d = r_q;
        if (wr && hit(bus_addr, A_CFG)) begin
            r_d.cfg = low_wdata;
        end

        bus_rdata = '0;
        if (rd) begin
            if (hit(bus_addr, A_STATUS)) begin
                bus_rdata = status_word;
            end else if (hit(bus_addr, A_MASK)) begin
                bus_rdata = mask_word;
            end else if (hit(bus_addr, A_CFG)) begin
                bus_rdata = {{(DATA_W-3){1'b0}}, r_q.cfg};
            end else if (page == PG_SHADOW && in_win) begin
                bus_rdata = shadow[sh_idx];
            end else if (page == PG_ACTIVE && in_win) begin
                bus_rdata = active[sh_idx];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_en   = r_q.cfg[CFG_EN];
    assign cfg_mode = {r_q.cfg[CFG_SR], r_q.cfg[CFG_PD]};

    // R8
    idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |-> bus_rdata == '0);

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && bus_we) |=> $stable({cfg_en, cfg_mode}));
endmodule

// File: rtl/dtb_handshake.sv
module dtb_handshake
    import dtb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       enable,
    input  logic [1:0] mode,
    output logic       ack,
    output logic       commit
);
    typedef struct packed {
        hs_state_e st;
    } hs_t;

    hs_t  h_d, h_q;
    logic allowed;

    always_comb begin
        allowed = enable && (mode != 2'b00);
        commit  = 1'b0;
        h_d     = h_q;
        unique case (h_q.st)
            HS_IDLE: begin
                if (req && allowed) begin
                    commit  = 1'b1;
                    h_d.st  = HS_HELD;
                end
            end
            HS_HELD: begin
                if (!req) begin
                    h_d.st = HS_IDLE;
                end
            end
            default: h_d.st = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '{st: HS_IDLE};
        end else begin
            h_q <= h_d;
        end
    end

    assign ack = (h_q.st == HS_HELD);

    // R3
    ack_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> ack);

    // R3
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack) |-> !$past(req));

    // R4
    blocked_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && !(enable && mode != 2'b00)) |=> !ack);
endmodule

// File: rtl/dtb_irq.sv
module dtb_irq
    import dtb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_evt,
    input  logic              ovf_evt,
    input  logic              st_clr_we,
    input  logic [1:0]        clr_bits,
    input  logic              mask_we,
    input  logic [1:0]        mask_bits,
    output logic [DATA_W-1:0] status_word,
    output logic [DATA_W-1:0] mask_word,
    output logic              irq
);
    typedef struct packed {
        logic [1:0] st;
        logic [1:0] mk;
    } ir_t;

    ir_t  s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (st_clr_we) begin
            s_d.st = s_q.st & ~clr_bits;
        end
        if (ovf_evt) begin
            s_d.st[0] = 1'b1;
        end
        if (done_evt) begin
            s_d.st[1] = 1'b1;
        end
        if (mask_we) begin
            s_d.mk = mask_bits;
        end

        status_word           = '0;
        status_word[BIT_OVF]  = s_q.st[0];
        status_word[BIT_DONE] = s_q.st[1];
        mask_word             = '0;
        mask_word[BIT_OVF]    = s_q.mk[0];
        mask_word[BIT_DONE]   = s_q.mk[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq = |(s_q.st & s_q.mk);

    // R6
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> status_word[BIT_OVF]);

    // R6
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_clr_we && clr_bits[1] && !done_evt) |=> !status_word[BIT_DONE]);
endmodule

// File: rtl/dtb_timing_bank.sv
module dtb_timing_bank #(
    parameter int NUM_TIMING = 44,
    parameter int DATA_W     = 32,
    localparam int IW        = (NUM_TIMING > 1) ? $clog2(NUM_TIMING) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              sh_we,
    input  logic [IW-1:0]                     sh_idx,
    input  logic [DATA_W-1:0]                 sh_wdata,
    input  logic                              commit,
    output logic [NUM_TIMING-1:0][DATA_W-1:0] shadow,
    output logic [NUM_TIMING-1:0][DATA_W-1:0] active
);
    typedef struct packed {
        logic [NUM_TIMING-1:0][DATA_W-1:0] sh;
        logic [NUM_TIMING-1:0][DATA_W-1:0] act;
    } bank_t;

    bank_t                 b_d, b_q;
    logic [NUM_TIMING-1:0] sel;

    for (genvar g = 0; g < NUM_TIMING; g++) begin : g_sel
        assign sel[g] = sh_we && (sh_idx == IW'(g));
    end

    always_comb begin
        b_d = b_q;
        if (commit) begin
            b_d.act = b_q.sh;
        end
        for (int i = 0; i < NUM_TIMING; i++) begin
            if (sel[i]) begin
                b_d.sh[i] = sh_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign shadow = b_q.sh;
    assign active = b_q.act;

    // R2
    whole_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> active == $past(shadow));

    // R1
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(active));

    // R1
    shadow_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_we && sh_idx == '0) |=> shadow[0] == $past(sh_wdata));
endmodule

// File: rtl/dtb_timing_shadow_bank.sv
module dtb_timing_shadow_bank
    import dtb_pkg::*;
#(
    parameter int NUM_TIMING = 44,
    parameter int DATA_W     = 32,
    localparam int IW        = (NUM_TIMING > 1) ? $clog2(NUM_TIMING) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_en,
    input  logic                         bus_we,
    input  logic [11:0]                  bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    input  logic                         clk_chg_req,
    output logic                         clk_chg_ack,
    input  logic                         refresh_ovf,
    output logic [NUM_TIMING*DATA_W-1:0] timing_active,
    output logic                         irq
);
    logic [NUM_TIMING-1:0][DATA_W-1:0] shadow_v, active_v;
    logic [DATA_W-1:0]                 status_word, mask_word;
    logic                              sh_we, force_upd, st_clr_we, mask_we;
    logic                              cfg_en, hs_commit, commit;
    logic [1:0]                        cfg_mode;
    logic [IW-1:0]                     sh_idx;

    dtb_regif #(.NUM_TIMING(NUM_TIMING), .DATA_W(DATA_W)) u_regif (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_en      (bus_en),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .low_wdata   (bus_wdata[2:0]),
        .shadow      (shadow_v),
        .active      (active_v),
        .status_word (status_word),
        .mask_word   (mask_word),
        .bus_rdata   (bus_rdata),
        .sh_we       (sh_we),
        .sh_idx      (sh_idx),
        .force_upd   (force_upd),
        .st_clr_we   (st_clr_we),
        .mask_we     (mask_we),
        .cfg_en      (cfg_en),
        .cfg_mode    (cfg_mode)
    );

    dtb_handshake u_hs (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (clk_chg_req),
        .enable (cfg_en),
        .mode   (cfg_mode),
        .ack    (clk_chg_ack),
        .commit (hs_commit)
    );

    assign commit = hs_commit || force_upd;

    dtb_timing_bank #(.NUM_TIMING(NUM_TIMING), .DATA_W(DATA_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .sh_we    (sh_we),
        .sh_idx   (sh_idx),
        .sh_wdata (bus_wdata),
        .commit   (commit),
        .shadow   (shadow_v),
        .active   (active_v)
    );

    dtb_irq #(.DATA_W(DATA_W)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .done_evt    (hs_commit),
        .ovf_evt     (refresh_ovf),
        .st_clr_we   (st_clr_we),
        .clr_bits    ({bus_wdata[BIT_DONE], bus_wdata[BIT_OVF]}),
        .mask_we     (mask_we),
        .mask_bits   ({bus_wdata[BIT_DONE], bus_wdata[BIT_OVF]}),
        .status_word (status_word),
        .mask_word   (mask_word),
        .irq         (irq)
    );

    assign timing_active = active_v;

    // R5
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_commit |=> status_word[BIT_DONE]);

    // R5
    force_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_upd && !hs_commit && !status_word[BIT_DONE]) |=> !status_word[BIT_DONE]);
endmodule

// File: tb/sim_dtb_timing_shadow_bank.sv
module sim_dtb_timing_shadow_bank;
    localparam int CLK_P = 10;
    localparam int NUM   = 44;
    localparam int DW    = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_en = 1'b0, bus_we = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [DW-1:0]     bus_wdata = '0;
    logic [DW-1:0]     bus_rdata;
    logic              clk_chg_req = 1'b0, clk_chg_ack;
    logic              refresh_ovf = 1'b0;
    logic [NUM*DW-1:0] timing_active;
    logic              irq;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    logic [31:0] m_sh  [NUM];
    logic [31:0] m_act [NUM];
    logic [31:0] m_st, m_mask;
    logic [2:0]  m_cfg;
    bit          m_busy;

    always #(CLK_P/2) clk = ~clk;

    dtb_timing_shadow_bank #(.NUM_TIMING(NUM), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .clk_chg_req(clk_chg_req), .clk_chg_ack(clk_chg_ack),
        .refresh_ovf(refresh_ovf), .timing_active(timing_active), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd();
        logic [5:0] w;
        w = bus_addr[7:2];
        if (!(bus_en && !bus_we) || bus_addr[1:0] != 2'b00) return 32'h0;
        if (bus_addr == 12'h000) return m_st;
        if (bus_addr == 12'h004) return m_mask;
        if (bus_addr == 12'h00C) return {29'b0, m_cfg};
        if (bus_addr[11:8] == 4'h1 && int'(w) < NUM) return m_sh[w];
        if (bus_addr[11:8] == 4'h2 && int'(w) < NUM) return m_act[w];
        return 32'h0;
    endfunction

    // behavioural reference model
    always @(posedge clk) begin
        bit ok, hs, frc;
        logic [5:0] w;
        if (!rst_n) begin
            for (int i = 0; i < NUM; i++) begin m_sh[i] = 0; m_act[i] = 0; end
            m_st = 0; m_mask = 0; m_cfg = 0; m_busy = 0;
        end else begin
            ok  = m_cfg[0] && (m_cfg[1] || m_cfg[2]);
            hs  = !m_busy && clk_chg_req && ok;
            frc = bus_en && bus_we && bus_addr == 12'h008 && bus_wdata[0];
            if (hs || frc) for (int i = 0; i < NUM; i++) m_act[i] = m_sh[i];
            w = bus_addr[7:2];
            if (bus_en && bus_we && bus_addr[1:0] == 2'b00) begin
                if (bus_addr[11:8] == 4'h1 && int'(w) < NUM) m_sh[w] = bus_wdata;
                if (bus_addr == 12'h000) m_st = m_st & ~(bus_wdata & 32'h18);
                if (bus_addr == 12'h004) m_mask = bus_wdata & 32'h18;
                if (bus_addr == 12'h00C) m_cfg = bus_wdata[2:0];
            end
            if (hs) m_st[4] = 1'b1;
            if (refresh_ovf) m_st[3] = 1'b1;
            m_busy = m_busy ? clk_chg_req : hs;
        end
    end

    // per-cycle comparison, a quarter period after the edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (rst_n && !finished) begin
                int bad;
                bad = -1;
                chk("R3 ack", {31'b0, clk_chg_ack}, {31'b0, m_busy});
                chk("R7 irq", {31'b0, irq}, {31'b0, |(m_st & m_mask)});
                chk("R8 rdata", bus_rdata, exp_rd());
                for (int i = 0; i < NUM; i++)
                    if (bad < 0 && timing_active[i*DW +: DW] !== m_act[i]) bad = i;
                if (bad < 0) chk("R2 active", 32'h0, 32'h0);
                else chk("R2 active entry", timing_active[bad*DW +: DW], m_act[bad]);
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
        bus_en = 0;
    endtask

    function automatic logic [31:0] pat(input int i);
        return 32'h1000_0000 + 32'(i) * 32'h0001_0203;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R9 reset state
        rd(12'h000, 32'h0, "R9 status");
        rd(12'h004, 32'h0, "R9 mask");
        rd(12'h00C, 32'h0, "R9 cfg");
        chk("R9 ack", {31'b0, clk_chg_ack}, 32'h0);
        chk("R9 irq", {31'b0, irq}, 32'h0);
        chk("R9 active0", timing_active[0 +: DW], 32'h0);

        // R1 stage shadow
        for (int i = 0; i < NUM; i++) wr(12'h100 + 12'(4*i), pat(i));
        rd(12'h100, pat(0), "R1 shadow0");
        rd(12'h100 + 12'(4*(NUM-1)), pat(NUM-1), "R1 shadow last");
        rd(12'h200, 32'h0, "R1 active0 unchanged");
        chk("R1 port active last", timing_active[(NUM-1)*DW +: DW], 32'h0);

        // R4 blocked requests
        for (int k = 0; k < 3; k++) begin
            logic [2:0] c;
            c = (k == 0) ? 3'b000 : (k == 1) ? 3'b001 : 3'b110;
            wr(12'h00C, {29'b0, c});
            @(negedge clk); clk_chg_req = 1;
            repeat (3) @(negedge clk);
            chk("R4 no ack", {31'b0, clk_chg_ack}, 32'h0);
            clk_chg_req = 0;
            rd(12'h000, 32'h0, "R4 no status");
            chk("R4 no commit", timing_active[0 +: DW], 32'h0);
        end

        // R10 config readback
        wr(12'h00C, 32'hFFFF_FFFB);
        rd(12'h00C, 32'h3, "R10 cfg");

        // R3 handshake with single commit
        @(negedge clk); clk_chg_req = 1;
        @(negedge clk);
        chk("R3 ack up", {31'b0, clk_chg_ack}, 32'h1);
        chk("R3 committed", timing_active[5*DW +: DW], pat(5));
        wr(12'h100, 32'hDEAD_BEEF);
        @(negedge clk);
        chk("R3 ack held", {31'b0, clk_chg_ack}, 32'h1);
        clk_chg_req = 0;
        @(negedge clk);
        chk("R3 ack down", {31'b0, clk_chg_ack}, 32'h0);
        chk("R3 single commit", timing_active[0 +: DW], pat(0));
        rd(12'h000, 32'h10, "R5 done flag");

        // R6 write-one-to-clear
        wr(12'h000, 32'h0000_0008);
        rd(12'h000, 32'h10, "R6 zero bits kept");
        wr(12'h000, 32'hFFFF_FFFF);
        rd(12'h000, 32'h0, "R6 cleared");

        // R7 mask and irq
        wr(12'h004, 32'hFFFF_FFFF);
        rd(12'h004, 32'h18, "R7 mask bits");
        chk("R7 irq low", {31'b0, irq}, 32'h0);
        @(negedge clk); refresh_ovf = 1;
        @(negedge clk); refresh_ovf = 0;
        chk("R7 irq high", {31'b0, irq}, 32'h1);
        rd(12'h000, 32'h08, "R5 overflow flag");
        // R6 set wins over clear in the same cycle
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = 12'h000; bus_wdata = 32'h08; refresh_ovf = 1;
        @(negedge clk);
        bus_en = 0; bus_we = 0; refresh_ovf = 0;
        rd(12'h000, 32'h08, "R6 set beats clear");
        wr(12'h004, 32'h10);
        chk("R7 masked off", {31'b0, irq}, 32'h0);

        // R2 forced update
        wr(12'h008, 32'hFFFF_FFFE);
        chk("R2 bit0 clear no copy", timing_active[0 +: DW], pat(0));
        wr(12'h008, 32'h1);
        chk("R2 forced copy", timing_active[0 +: DW], 32'hDEAD_BEEF);
        rd(12'h000, 32'h08, "R5 force sets no flag");

        // R8 read-only and unmapped
        wr(12'h204, 32'h1234_5678);
        rd(12'h204, pat(1), "R8 active read-only");
        rd(12'h008, 32'h0, "R8 control reads 0");
        rd(12'h300, 32'h0, "R8 unmapped");
        rd(12'h100 + 12'(4*NUM), 32'h0, "R8 beyond last entry");
        rd(12'h101, 32'h0, "R8 unaligned");

        // mixed traffic checked every cycle against the model
        for (int n = 0; n < 3000; n++) begin
            int sel;
            @(negedge clk);
            sel = $urandom % 8;
            bus_en = ($urandom % 2) == 1;
            bus_we = ($urandom % 2) == 1;
            case (sel)
                0: bus_addr = 12'h000;
                1: bus_addr = 12'h004;
                2: bus_addr = 12'h008;
                3: bus_addr = 12'h00C;
                4, 5: bus_addr = 12'h100 + 12'(4 * ($urandom % 64));
                6: bus_addr = 12'h200 + 12'(4 * ($urandom % 64));
                default: bus_addr = 12'h300;
            endcase
            bus_wdata = $urandom;
            if (($urandom % 5) == 0) clk_chg_req = ~clk_chg_req;
            refresh_ovf = ($urandom % 8) == 0;
        end
        @(negedge clk);
        bus_en = 0; bus_we = 0; clk_chg_req = 0; refresh_ovf = 0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule